// File: doc/BRIEF.md
# NOR Flash Command Cycle Sequencer

This block turns one requested flash operation into the ordered series of bus write cycles that a parallel NOR flash part needs to start that operation. A request arrives on a valid/ready handshake. It carries a 3-bit opcode, the base address of the flash bank, a target address and a data word. The sequencer then presents one (address, data) write at a time to a downstream bus master. Each write stays on the bus until the master acknowledges it. A one-cycle completion pulse follows the last acknowledged write.

Most operations open with a two-write unlock preamble. Command addresses are formed from a small command offset and the bank base. When the device is 16 bits wide, the offset is doubled before it is added to the base. The width select is sampled when a request is accepted and holds for the whole sequence. The block does not cover external bus timing or waiting for the flash to finish its operation.

Top module: `nor_cmd_sequencer`

## Requirements
- R1: After reset `req_ready` is 1, and `bus_valid`, `done` and `err` are 0.
- R2: Opcodes 1, 2, 3 and 4 begin with two unlock writes: data 0xAA at command offset 0x555, then data 0x55 at command offset 0x2AA.
- R3: Opcode 1 (identifier entry) is three writes; the third writes 0x90 at offset 0x555.
- R4: Opcode 2 (word program) is four writes: the unlock pair, 0xA0 at offset 0x555, then the request data word at the target address.
- R5: Opcode 3 (sector erase) is six writes: the unlock pair, 0x80 at 0x555, 0xAA at 0x555, 0x55 at 0x2AA, and finally 0x30 at the target address.
- R6: Opcode 4 (whole-chip erase) uses the same first five writes as opcode 3, and its sixth write is 0x10 at offset 0x555.
- R7: Opcode 0 (return to read array) is a single write of 0xF0 at the bank base address.
- R8: Opcode 5 (query mode entry) is a single write of 0x98 at command offset 0x55.
- R9: A command address is the bank base plus the offset, with the offset shifted left by one when `wide_mode` is 1. `wide_mode` is taken at acceptance, so changing it later does not affect the running sequence. Command bytes sit zero-extended in the low bits of `bus_data`.
- R10: `req_ready` is 0 while a sequence runs. Each write holds `bus_addr` and `bus_data` steady on `bus_valid` until `bus_ack` is seen.
- R11: `done` is high for exactly one cycle. It follows the clock edge at which the last write is acknowledged, with `err` low and `req_ready` high again.
- R12: An accepted opcode of 6 or 7 issues no bus write. It raises `done` and `err` together in the cycle right after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_op | input | 3 | Operation code |
| req_bank | input | AW | Bank base address |
| req_addr | input | AW | Target address for program or sector erase |
| req_data | input | DW | Data word for program |
| wide_mode | input | 1 | 1 = 16-bit device, 0 = 8-bit device |
| bus_valid | output | 1 | Write cycle presented |
| bus_addr | output | AW | Write address |
| bus_data | output | DW | Write data |
| bus_ack | input | 1 | Downstream master took the write |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Unknown opcode, high together with done |

## Verification
The assertions assume that `bus_ack` is raised only while `bus_valid` is high. They also assume that a requester keeps its request until it sees `req_ready`. The stability check relies on the acknowledger never taking a write in the same cycle it first appears, so a write stays visible for at least one full cycle. The bench's responder meets all of these. It acknowledges only a write it has already observed at a falling edge, and it drops `bus_ack` for one cycle after each handshake. Its stall of zero to two cycles varies per run, and every opcode is swept over both widths and two bank/target pairs. After each acceptance the bench flips `wide_mode` and clears `req_op`, which shows that the sampled request values stay in force.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  localparam int OP_W   = 3;
  localparam int STEP_W = 3;
  localparam int OFF_W  = 12;

  localparam logic [OP_W-1:0] OPC_RDARRAY = 3'd0;
  localparam logic [OP_W-1:0] OPC_IDENT   = 3'd1;
  localparam logic [OP_W-1:0] OPC_PROG    = 3'd2;
  localparam logic [OP_W-1:0] OPC_SECTOR  = 3'd3;
  localparam logic [OP_W-1:0] OPC_CHIP    = 3'd4;
  localparam logic [OP_W-1:0] OPC_QUERY   = 3'd5;
  localparam logic [OP_W-1:0] OPC_LAST    = OPC_QUERY;

  // where a write cycle takes its address and data from
  typedef enum logic [1:0] {
    SRC_CMD      = 2'd0,   // bank + scaled offset, command byte
    SRC_TGT_CMD  = 2'd1,   // target address, command byte
    SRC_TGT_USER = 2'd2    // target address, request data word
  } cyc_src_e;

  typedef struct packed {
    cyc_src_e             src;
    logic [OFF_W-1:0]     off;
    logic [7:0]           code;
    logic                 last;
  } step_t;

  function automatic step_t mk_step(cyc_src_e s, logic [OFF_W-1:0] o,
                                    logic [7:0] c, logic l);
    step_t r;
    r.src  = s;
    r.off  = o;
    r.code = c;
    r.last = l;
    return r;
  endfunction

  function automatic logic op_known(logic [OP_W-1:0] op);
    return op <= OPC_LAST;
  endfunction

  // command offset turned into a byte distance from the bank base
  function automatic logic [OFF_W:0] cmd_span(logic [OFF_W-1:0] off, logic wide);
    return wide ? {off, 1'b0} : {1'b0, off};
  endfunction

  // step table: the index counts the writes already taken
  function automatic step_t step_lookup(logic [OP_W-1:0] op, logic [STEP_W-1:0] idx);
    step_t s;
    s = mk_step(SRC_CMD, 12'h000, 8'hF0, 1'b1);
    if (op == OPC_RDARRAY) begin
      s = mk_step(SRC_CMD, 12'h000, 8'hF0, 1'b1);
    end else if (op == OPC_QUERY) begin
      s = mk_step(SRC_CMD, 12'h055, 8'h98, 1'b1);
    end else begin
      case (idx)
        3'd0: s = mk_step(SRC_CMD, 12'h555, 8'hAA, 1'b0);
        3'd1: s = mk_step(SRC_CMD, 12'h2AA, 8'h55, 1'b0);
        3'd2: begin
          if (op == OPC_IDENT)     s = mk_step(SRC_CMD, 12'h555, 8'h90, 1'b1);
          else if (op == OPC_PROG) s = mk_step(SRC_CMD, 12'h555, 8'hA0, 1'b0);
          else                     s = mk_step(SRC_CMD, 12'h555, 8'h80, 1'b0);
        end
        3'd3: begin
          if (op == OPC_PROG) s = mk_step(SRC_TGT_USER, 12'h000, 8'h00, 1'b1);
          else                s = mk_step(SRC_CMD, 12'h555, 8'hAA, 1'b0);
        end
        3'd4: s = mk_step(SRC_CMD, 12'h2AA, 8'h55, 1'b0);
        default: begin
          if (op == OPC_SECTOR) s = mk_step(SRC_TGT_CMD, 12'h000, 8'h30, 1'b1);
          else                  s = mk_step(SRC_CMD, 12'h555, 8'h10, 1'b1);
        end
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/nor_seq_plan.sv
module nor_seq_plan
  import nor_seq_pkg::*;
(
  input  logic [OP_W-1:0]   op,
  input  logic [STEP_W-1:0] idx,
  output cyc_src_e          src,
  output logic [OFF_W-1:0]  off,
  output logic [7:0]        code,
  output logic              last
);

  step_t cur;

  always_comb cur = step_lookup(op, idx);

  assign src  = cur.src;
  assign off  = cur.off;
  assign code = cur.code;
  assign last = cur.last;

endmodule

// File: rtl/nor_seq_addr.sv
module nor_seq_addr
  import nor_seq_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic [AW-1:0]    bank,
  input  logic [AW-1:0]    tgt,
  input  logic [DW-1:0]    user,
  input  logic             wide,
  input  cyc_src_e         src,
  input  logic [OFF_W-1:0] off,
  input  logic [7:0]       code,
  output logic [AW-1:0]    addr,
  output logic [DW-1:0]    data
);

  logic [OFF_W:0] span;
  logic [DW-1:0]  code_ext;

  assign span = cmd_span(off, wide);

  generate
    if (DW > 8) begin : g_code_pad
      assign code_ext = {{(DW-8){1'b0}}, code};
    end else begin : g_code_cut
      assign code_ext = code[DW-1:0];
    end
  endgenerate

  always_comb begin
    addr = (src == SRC_CMD) ? (bank + AW'(span)) : tgt;
    data = (src == SRC_TGT_USER) ? user : code_ext;
  end

endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
  import nor_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_known,
  input  logic              bus_ack,
  input  logic              step_last,
  output logic              req_ready,
  output logic              accept,
  output logic              busy,
  output logic              fire,
  output logic              done,
  output logic              err,
  output logic [STEP_W-1:0] idx
);

  logic              busy_q;
  logic              done_q;
  logic              err_q;
  logic [STEP_W-1:0] idx_q;

  assign req_ready = !busy_q;
  assign accept    = req_valid && !busy_q;
  assign fire      = busy_q && bus_ack;
  assign busy      = busy_q;
  assign done      = done_q;
  assign err       = err_q;
  assign idx       = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      idx_q  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept) begin
        idx_q <= '0;
        if (req_known) begin
          busy_q <= 1'b1;
        end else begin
          done_q <= 1'b1;
          err_q  <= 1'b1;
        end
      end else if (fire) begin
        if (step_last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/nor_cmd_sequencer.sv
module nor_cmd_sequencer
  import nor_seq_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [2:0]      req_op,
  input  logic [AW-1:0]   req_bank,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_data,
  input  logic            wide_mode,
  output logic            bus_valid,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_data,
  input  logic            bus_ack,
  output logic            done,
  output logic            err
);

  // request held for the running sequence
  logic [OP_W-1:0] op_q;
  logic [AW-1:0]   bank_q;
  logic [AW-1:0]   tgt_q;
  logic [DW-1:0]   user_q;
  logic            wide_q;

  // named internal events
  logic              req_accept;
  logic              req_known;
  logic              seq_busy;
  logic              step_fire;
  logic              step_last;
  logic [STEP_W-1:0] step_idx;
  cyc_src_e          cur_src;
  logic [OFF_W-1:0]  cur_off;
  logic [7:0]        cur_code;

  assign req_known = op_known(req_op);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= OPC_RDARRAY;
      bank_q <= '0;
      tgt_q  <= '0;
      user_q <= '0;
      wide_q <= 1'b0;
    end else if (req_accept) begin
      op_q   <= req_op;
      bank_q <= req_bank;
      tgt_q  <= req_addr;
      user_q <= req_data;
      wide_q <= wide_mode;
    end
  end

  nor_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_known (req_known),
    .bus_ack   (bus_ack),
    .step_last (step_last),
    .req_ready (req_ready),
    .accept    (req_accept),
    .busy      (seq_busy),
    .fire      (step_fire),
    .done      (done),
    .err       (err),
    .idx       (step_idx)
  );

  nor_seq_plan u_plan (
    .op   (op_q),
    .idx  (step_idx),
    .src  (cur_src),
    .off  (cur_off),
    .code (cur_code),
    .last (step_last)
  );

  nor_seq_addr #(.AW(AW), .DW(DW)) u_addr (
    .bank (bank_q),
    .tgt  (tgt_q),
    .user (user_q),
    .wide (wide_q),
    .src  (cur_src),
    .off  (cur_off),
    .code (cur_code),
    .addr (bus_addr),
    .data (bus_data)
  );

  assign bus_valid = seq_busy;

endmodule

// File: rtl/nor_seq_checker.sv
module nor_seq_checker
  import nor_seq_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [2:0]      req_op,
  input logic            bus_valid,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_data,
  input logic            bus_ack,
  input logic            done,
  input logic            err,
  input logic            step_fire,
  input logic            step_last
);

  assert_ready_low_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !req_ready);

  assert_hold_until_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ack) |=> (bus_valid && $stable(bus_addr) && $stable(bus_data)));

  assert_done_after_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && step_last) |=> (done && !err && !bus_valid && req_ready));

  assert_done_no_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_valid);

  assert_err_with_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  assert_unknown_op_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_op > OPC_LAST)) |=> (done && err && !bus_valid));

endmodule

bind nor_cmd_sequencer nor_seq_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_op    (req_op),
  .bus_valid (bus_valid),
  .bus_addr  (bus_addr),
  .bus_data  (bus_data),
  .bus_ack   (bus_ack),
  .done      (done),
  .err       (err),
  .step_fire (step_fire),
  .step_last (step_last)
);

// File: tb/tb_nor_cmd_sequencer.sv
`timescale 1ns/1ps
module tb_nor_cmd_sequencer;

  localparam int AW = 24;
  localparam int DW = 16;
  localparam int EOFF [6] = '{'h555, 'h2AA, 'h555, 'h555, 'h2AA, 'h555};
  localparam int ECOD [6] = '{'hAA, 'h55, 'h80, 'hAA, 'h55, 'h10};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [2:0]    req_op = 3'd0;
  logic [AW-1:0] req_bank = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          wide_mode = 1'b0;
  logic          bus_valid;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;
  logic          bus_ack = 1'b0;
  logic          done;
  logic          err;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int stall = 0;
  int wait_cnt = 0;
  int log_n = 0;
  int last_ack_cyc = -1;
  bit rdy_viol = 0;
  bit finished = 0;
  logic [AW-1:0] log_a [8];
  logic [DW-1:0] log_d [8];

  always #2.5 clk = ~clk;

  nor_cmd_sequencer #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_bank(req_bank), .req_addr(req_addr), .req_data(req_data),
    .wide_mode(wide_mode), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_ack(bus_ack), .done(done), .err(err)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // downstream responder: logs and acknowledges each write after a stall
  always @(negedge clk) begin
    if (bus_valid && req_ready) rdy_viol = 1;
    if (!rst_n) begin
      bus_ack = 1'b0;
      wait_cnt = 0;
    end else if (bus_ack) begin
      bus_ack = 1'b0;
    end else if (bus_valid) begin
      if (wait_cnt < stall) begin
        wait_cnt++;
      end else begin
        if (log_n < 8) begin
          log_a[log_n] = bus_addr;
          log_d[log_n] = bus_data;
        end
        log_n++;
        last_ack_cyc = cyc;
        bus_ack = 1'b1;
        wait_cnt = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_len(input int op);
    case (op)
      0: return 1;
      1: return 3;
      2: return 4;
      3: return 6;
      4: return 6;
      5: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic string op_tag(input int op, input int i);
    if (op >= 1 && op <= 4 && i < 2) return "R2";
    case (op)
      0: return "R7";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic exp_cycle(input int op, input int i, input logic [AW-1:0] bank,
                           input logic [AW-1:0] tgt, input logic [DW-1:0] usr,
                           input bit wide, output logic [AW-1:0] a,
                           output logic [DW-1:0] d);
    int off = 0;
    int code = 0;
    bit at_tgt = 0;
    bit use_usr = 0;
    if (op == 0) begin off = 0; code = 'hF0; end
    else if (op == 5) begin off = 'h55; code = 'h98; end
    else begin
      off = EOFF[i];
      code = ECOD[i];
      if (op == 1 && i == 2) code = 'h90;
      if (op == 2 && i == 2) code = 'hA0;
      if (op == 2 && i == 3) use_usr = 1;
      if (op == 3 && i == 5) begin at_tgt = 1; code = 'h30; end
    end
    if (at_tgt || use_usr) a = tgt;
    else a = bank + AW'(wide ? off * 2 : off);
    d = use_usr ? usr : DW'(code);
  endtask

  task automatic run_op(input int op, input logic [AW-1:0] bank, input logic [AW-1:0] tgt,
                        input logic [DW-1:0] usr, input bit wide, input int stl);
    int c0;
    int dcyc = 0;
    bit got = 0;
    bit de = 0;
    bit dr = 0;
    logic [AW-1:0] ea;
    logic [DW-1:0] ed;
    @(negedge clk);
    log_n = 0;
    rdy_viol = 0;
    stall = stl;
    last_ack_cyc = -1;
    req_op = op[2:0];
    req_bank = bank;
    req_addr = tgt;
    req_data = usr;
    wide_mode = wide;
    req_valid = 1'b1;
    c0 = cyc;
    for (int k = 0; k < 300 && !got; k++) begin
      @(negedge clk);
      if (k == 0) begin
        req_valid = 1'b0;
        wide_mode = ~wide;
        req_op = 3'd0;
        req_data = ~usr;
        req_addr = ~tgt;
      end
      if (done) begin
        got = 1;
        dcyc = cyc;
        de = err;
        dr = req_ready;
      end
    end
    chk(got, "R11", "done seen", got, 1);
    if (op > 5) begin
      chk(dcyc == c0 + 1, "R12", "done cycle after accept", dcyc - c0, 1);
      chk(de, "R12", "err with done", de, 1);
      chk(log_n == 0, "R12", "bus writes for unknown op", log_n, 0);
    end else begin
      chk(log_n == exp_len(op), op_tag(op, 9), "write count", log_n, exp_len(op));
      for (int i = 0; i < exp_len(op) && i < log_n; i++) begin
        exp_cycle(op, i, bank, tgt, usr, wide, ea, ed);
        chk(log_a[i] == ea, {op_tag(op, i), "/R9"}, $sformatf("addr of write %0d", i),
            log_a[i], ea);
        chk(log_d[i] == ed, op_tag(op, i), $sformatf("data of write %0d", i), log_d[i], ed);
      end
      chk(dcyc == last_ack_cyc + 1, "R11", "done after last ack", dcyc - last_ack_cyc, 1);
      chk(!de, "R11", "err on good op", de, 0);
      chk(dr, "R11", "ready at done", dr, 1);
      chk(!rdy_viol, "R10", "ready high during writes", rdy_viol, 0);
    end
    @(negedge clk);
    chk(!done, "R11", "done width", done, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(bus_valid === 1'b0, "R1", "bus_valid after reset", bus_valid, 0);
    chk(done === 1'b0, "R1", "done after reset", done, 0);
    chk(err === 1'b0, "R1", "err after reset", err, 0);
    for (int w = 0; w < 2; w++) begin
      for (int s = 0; s < 2; s++) begin
        for (int op = 0; op < 8; op++) begin
          run_op(op,
                 s ? 24'h40_0000 : 24'h00_0000,
                 s ? 24'h41_2346 : 24'h00_1A2C,
                 16'hC3A5 ^ DW'(op * 16'h0111),
                 w[0], (op + w + s) % 3);
        end
      end
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule